// File: doc/BRIEF.md
# IO Address Translation Page Walker

This block converts 32-bit DMA addresses issued by devices into physical memory addresses. Translation applies only inside a window at the top of the address space. A size code in the control register picks the window's lower bound. For each request inside the window, the block computes where the page-table entry for that 4 KiB page sits in memory. It then issues a single-beat read for that entry, checks the entry's permission bits and returns the rebuilt physical address.

Requests outside the window are answered at once with the address unchanged, and so are all requests while translation is off. In both cases no memory read takes place. Software configures the block through a small word-indexed register port. The port holds a control register and a table base register, and it has two write-only flush slots that leave the translation state untouched. The requester sees a simple idle/accept handshake and a one-cycle response pulse carrying the address and an error flag.

Top module: `io_xlate_walker`

## Requirements
- R1: After reset the control and table base registers read as zero, `req_ready` is 1, and `rsp_valid` and `mem_rd_valid` are 0.
- R2: Register index 0 reads back the control register and index 1 reads back the table base, each holding the full 32-bit written value. Any other index reads zero. Writes to index 5 (flush all) or index 6 (flush one page), or to any other unused index, leave both registers unchanged.
- R3: Every write to index 0 sets the window start from control bits [4:2]. The start is 0xFFFFFFFF shifted left by 24 plus the code, so code 0 gives 0xFF000000 and code 7 gives 0x80000000.
- R4: The request is passed through when control bit 0 (enable) is 0, or when the request address is below the window start. In that case `rsp_valid` rises in the cycle after acceptance, with `rsp_addr` equal to the request address and `rsp_err` 0, and `mem_rd_valid` never rises.
- R5: Otherwise, from the cycle after acceptance, `mem_rd_valid` is held at 1 until `mem_rd_data_valid` is seen. `mem_rd_addr` equals (base << 4) + 4 × ((address − window start) >> 12).
- R6: With the default parameters, the memory port delivers each entry with its bytes reversed, and the block restores the byte order before decoding.
- R7: For an accepted entry, `rsp_addr` = ((entry AND 0x07FFFF00) << 4) + address[11:0], truncated to 32 bits, and `rsp_err` is 0. The response appears in the cycle after the entry arrives.
- R8: An entry whose valid bit (bit 1) is 0 gives `rsp_err` = 1 and `rsp_addr` = 0.
- R9: A write request (`req_write` = 1) to an entry whose writable bit (bit 2) is 0 gives `rsp_err` = 1 and `rsp_addr` = 0. A read request to the same entry succeeds.
- R10: `req_ready` is 1 only while idle. A request presented while busy is ignored, and `rsp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` |
| req_valid | input | 1 | Translation request present |
| req_write | input | 1 | Request is a device write |
| req_addr | input | 32 | Device address to translate |
| req_ready | output | 1 | Block is idle and accepts a request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_addr | output | 32 | Translated or passed-through address |
| rsp_err | output | 1 | Entry invalid or write not permitted |
| mem_rd_valid | output | 1 | Entry read request, held until data returns |
| mem_rd_addr | output | 32 | Byte address of the entry |
| mem_rd_data_valid | input | 1 | Entry data present |
| mem_rd_data | input | 32 | Entry data from memory |

## Verification
The hardest case to reach from the ports is the exact edge of each window size. Only a control write followed by addresses one below and exactly at the start tells a correct window decode apart from an off-by-one compare or a wrong shift. The bench walks all eight size codes. For each one it sends an address one below the start, which must pass through with no memory read, and an address five pages above the start, which must fetch from base plus twenty. A second hard case is a request that arrives while a fetch is pending. The bench raises `req_valid` with a different address in the middle of a stretched memory wait, then checks that the response belongs to the first request and that no second fetch follows.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int unsigned XW_AW    = 32;
    localparam int unsigned XW_IDX_W = 3;

    localparam int unsigned IDX_CTRL       = 0;
    localparam int unsigned IDX_BASE       = 1;
    localparam int unsigned IDX_FLUSH_ALL  = 5;
    localparam int unsigned IDX_FLUSH_PAGE = 6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RESP  = 2'd2
    } walk_state_e;

    typedef struct packed {
        walk_state_e         state;
        logic [XW_AW-1:0]    addr;
        logic                wr;
        logic [XW_AW-1:0]    eaddr;
        logic [XW_AW-1:0]    rsp_addr;
        logic                rsp_err;
    } walk_t;

    typedef struct packed {
        logic [XW_AW-1:0] ctrl;
        logic [XW_AW-1:0] base;
        logic [XW_AW-1:0] win;
    } cfg_t;
endpackage

// File: rtl/xw_regs.sv
module xw_regs
    import xw_pkg::*;
#(
    parameter int unsigned DW           = XW_AW,
    parameter int unsigned IW           = XW_IDX_W,
    parameter int unsigned WIN_MIN_LOG2 = 24,
    parameter int unsigned CODE_LSB     = 2,
    parameter int unsigned CODE_W       = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] base_q,
    output logic [DW-1:0] win_q
);
    localparam logic [IW-1:0] I_CTRL = IW'(IDX_CTRL);
    localparam logic [IW-1:0] I_BASE = IW'(IDX_BASE);

    cfg_t cfg_d, cfg_q;
    logic [CODE_W-1:0] code;

    assign code = wdata[CODE_LSB +: CODE_W];

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            if (idx == I_CTRL) begin
                cfg_d.ctrl = wdata;
                cfg_d.win  = {DW{1'b1}} << (WIN_MIN_LOG2 + 32'(code));
            end else if (idx == I_BASE) begin
                cfg_d.base = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        case (idx)
            I_CTRL:  rdata = cfg_q.ctrl;
            I_BASE:  rdata = cfg_q.base;
            default: rdata = '0;
        endcase
    end

    assign ctrl_q = cfg_q.ctrl;
    assign base_q = cfg_q.base;
    assign win_q  = cfg_q.win;
endmodule

// File: rtl/xw_calc.sv
module xw_calc
    import xw_pkg::*;
#(
    parameter int unsigned DW         = XW_AW,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned TBL_SHIFT  = 4,
    parameter int unsigned ENTRY_LOG2 = 2,
    parameter int unsigned PPN_LSB    = 8,
    parameter int unsigned PPN_W      = 19,
    parameter int unsigned VALID_BIT  = 1,
    parameter int unsigned WRITE_BIT  = 2,
    parameter bit          LE_MEM     = 1'b1
) (
    input  logic          enable,
    input  logic [DW-1:0] win_start,
    input  logic [DW-1:0] base,
    input  logic [DW-1:0] new_addr,
    input  logic [DW-1:0] held_addr,
    input  logic          held_wr,
    input  logic [DW-1:0] raw_entry,
    output logic          bypass,
    output logic [DW-1:0] entry_addr,
    output logic [DW-1:0] phys_addr,
    output logic          fault
);
    localparam int unsigned NBYTES = DW / 8;

    logic [DW-1:0]    entry;
    logic [DW-1:0]    rel;
    logic [PPN_W-1:0] ppn;
    logic             unused_bits;

    generate
        if (LE_MEM) begin : g_swap
            for (genvar b = 0; b < NBYTES; b++) begin : g_byte
                assign entry[b*8 +: 8] = raw_entry[(NBYTES-1-b)*8 +: 8];
            end
        end else begin : g_direct
            assign entry = raw_entry;
        end
    endgenerate

    assign bypass     = !enable || (new_addr < win_start);
    assign rel        = new_addr - win_start;
    assign entry_addr = (base << TBL_SHIFT) + ((rel >> PAGE_SHIFT) << ENTRY_LOG2);

    assign ppn        = entry[PPN_LSB +: PPN_W];
    assign phys_addr  = (DW'(ppn) << PAGE_SHIFT) | DW'(held_addr[PAGE_SHIFT-1:0]);
    assign fault      = !entry[VALID_BIT] || (held_wr && !entry[WRITE_BIT]);

    assign unused_bits = ^{entry, held_addr, rel};
endmodule

// File: rtl/io_xlate_walker.sv
module io_xlate_walker
    import xw_pkg::*;
#(
    parameter int unsigned AW           = XW_AW,
    parameter int unsigned IW           = XW_IDX_W,
    parameter int unsigned WIN_MIN_LOG2 = 24,
    parameter int unsigned PAGE_SHIFT   = 12,
    parameter int unsigned TBL_SHIFT    = 4,
    parameter bit          LE_MEM       = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [IW-1:0] reg_idx,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_addr,
    output logic          rsp_err,
    output logic          mem_rd_valid,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_data_valid,
    input  logic [AW-1:0] mem_rd_data
);
    logic [AW-1:0] ctrl_q, base_q, win_start_q;
    logic          bypass, fault;
    logic [AW-1:0] entry_addr, phys_addr;
    walk_t         w_d, w_q;

    xw_regs #(
        .DW(AW), .IW(IW), .WIN_MIN_LOG2(WIN_MIN_LOG2), .CODE_LSB(2), .CODE_W(3)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .idx(reg_idx), .wdata(reg_wdata),
        .rdata(reg_rdata), .ctrl_q(ctrl_q), .base_q(base_q), .win_q(win_start_q)
    );

    xw_calc #(
        .DW(AW), .PAGE_SHIFT(PAGE_SHIFT), .TBL_SHIFT(TBL_SHIFT), .ENTRY_LOG2(2),
        .PPN_LSB(8), .PPN_W(19), .VALID_BIT(1), .WRITE_BIT(2), .LE_MEM(LE_MEM)
    ) u_calc (
        .enable(ctrl_q[0]), .win_start(win_start_q), .base(base_q),
        .new_addr(req_addr), .held_addr(w_q.addr), .held_wr(w_q.wr),
        .raw_entry(mem_rd_data), .bypass(bypass), .entry_addr(entry_addr),
        .phys_addr(phys_addr), .fault(fault)
    );

    always_comb begin
        w_d = w_q;
        case (w_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    w_d.addr = req_addr;
                    w_d.wr   = req_write;
                    if (bypass) begin
                        w_d.state    = ST_RESP;
                        w_d.rsp_addr = req_addr;
                        w_d.rsp_err  = 1'b0;
                    end else begin
                        w_d.state = ST_FETCH;
                        w_d.eaddr = entry_addr;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_rd_data_valid) begin
                    w_d.state    = ST_RESP;
                    w_d.rsp_err  = fault;
                    w_d.rsp_addr = fault ? '0 : phys_addr;
                end
            end
            default: w_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign req_ready    = (w_q.state == ST_IDLE);
    assign mem_rd_valid = (w_q.state == ST_FETCH);
    assign mem_rd_addr  = w_q.eaddr;
    assign rsp_valid    = (w_q.state == ST_RESP);
    assign rsp_addr     = w_q.rsp_addr;
    assign rsp_err      = w_q.rsp_err;
endmodule

// File: rtl/io_xlate_walker_chk.sv
module io_xlate_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [2:0]  reg_idx,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic [31:0] rsp_addr,
    input logic        rsp_err,
    input logic        mem_rd_valid,
    input logic [31:0] mem_rd_addr,
    input logic        mem_rd_data_valid,
    input logic        ctrl_en,
    input logic [31:0] ctrl_val,
    input logic [31:0] base_val,
    input logic [31:0] win_start
);
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid || rsp_valid) |-> !req_ready);

    p_fetch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_data_valid) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_addr == 32'h0));

    p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (!ctrl_en || req_addr < win_start))
        |=> (rsp_valid && !rsp_err && !mem_rd_valid && rsp_addr == $past(req_addr)));

    p_flush_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_idx == 3'd5 || reg_idx == 3'd6))
        |=> ($stable(ctrl_val) && $stable(base_val)));
endmodule

bind io_xlate_walker io_xlate_walker_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_err(rsp_err),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data_valid(mem_rd_data_valid), .ctrl_en(ctrl_q[0]),
    .ctrl_val(ctrl_q), .base_val(base_q), .win_start(win_start_q)
);

// File: tb/io_xlate_walker_bench.sv
module io_xlate_walker_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic        rsp_err;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_data_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    io_xlate_walker u_io_xlate_walker (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_err(rsp_err),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data_valid(mem_rd_data_valid), .mem_rd_data(mem_rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] bswap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [31:0] start_of(input int code);
        case (code)
            0: return 32'hFF000000;
            1: return 32'hFE000000;
            2: return 32'hFC000000;
            3: return 32'hF8000000;
            4: return 32'hF0000000;
            5: return 32'hE0000000;
            6: return 32'hC0000000;
            default: return 32'h80000000;
        endcase
    endfunction

    task automatic reg_write(input logic [2:0] idx, input logic [31:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_check(input string tag, input logic [2:0] idx, input logic [31:0] exp);
        reg_idx = idx;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    // Drives one request; for a fetch, returns the entry (bytes reversed) after 'delay' wait cycles.
    task automatic xlate(input string tag, input logic [31:0] addr, input logic wr,
                         input bit fetch, input logic [31:0] exp_eaddr,
                         input logic [31:0] entry, input int delay,
                         input logic [31:0] exp_addr, input logic exp_err);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
        if (fetch) begin
            chk({tag, " fetch issued R5"}, 32'(mem_rd_valid), 32'd1);
            chk({tag, " entry address R5"}, mem_rd_addr, exp_eaddr);
            for (int i = 0; i < delay; i++) begin
                @(negedge clk);
                chk({tag, " fetch held R5"}, 32'(mem_rd_valid), 32'd1);
            end
            mem_rd_data_valid = 1'b1; mem_rd_data = bswap(entry);
            @(negedge clk);
            mem_rd_data_valid = 1'b0; mem_rd_data = '0;
        end else begin
            chk({tag, " no fetch R4"}, 32'(mem_rd_valid), 32'd0);
        end
        chk({tag, " rsp_valid R10"}, 32'(rsp_valid), 32'd1);
        chk({tag, " rsp_addr"}, rsp_addr, exp_addr);
        chk({tag, " rsp_err"}, 32'(rsp_err), 32'(exp_err));
        @(negedge clk);
        chk({tag, " pulse ends R10"}, 32'(rsp_valid), 32'd0);
        chk({tag, " idle again R10"}, 32'(req_ready), 32'd1);
    endtask

    function automatic logic [31:0] exp_pa(input logic [31:0] e, input logic [31:0] a);
        return ((e & 32'h07FFFF00) << 4) + (a & 32'h00000FFF);
    endfunction

    task automatic t_reset();
        reg_check("R1 ctrl after reset", 3'd0, 32'h0);
        reg_check("R1 base after reset", 3'd1, 32'h0);
        chk("R1 req_ready", 32'(req_ready), 32'd1);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 mem_rd_valid", 32'(mem_rd_valid), 32'd0);
    endtask

    task automatic t_regs();
        reg_write(3'd0, 32'hA5C3_0010);
        reg_write(3'd1, 32'h1234_5678);
        reg_check("R2 ctrl readback", 3'd0, 32'hA5C3_0010);
        reg_check("R2 base readback", 3'd1, 32'h1234_5678);
        reg_write(3'd5, 32'hFFFF_FFFF);
        reg_write(3'd6, 32'h0000_0000);
        reg_write(3'd3, 32'h5555_5555);
        reg_check("R2 ctrl after flush", 3'd0, 32'hA5C3_0010);
        reg_check("R2 base after flush", 3'd1, 32'h1234_5678);
        reg_check("R2 flush slot reads zero", 3'd5, 32'h0);
        reg_check("R2 unused slot reads zero", 3'd3, 32'h0);
    endtask

    task automatic t_disabled();
        reg_write(3'd0, 32'h0000_0000);
        xlate("R4 disabled", 32'hFF00_1234, 1'b0, 1'b0, 32'h0, 32'h0, 0, 32'hFF00_1234, 1'b0);
    endtask

    task automatic t_window_codes();
        reg_write(3'd1, 32'h0002_0000);
        for (int c = 0; c < 8; c++) begin
            logic [31:0] s;
            s = start_of(c);
            reg_write(3'd0, 32'(c) << 2 | 32'h1);
            xlate($sformatf("R3 R4 code %0d below", c), s - 32'd1, 1'b0, 1'b0, 32'h0,
                  32'h0, 0, s - 32'd1, 1'b0);
            xlate($sformatf("R3 R5 code %0d inside", c), s + 32'h5000, 1'b0, 1'b1,
                  32'h0020_0000 + 32'd20, 32'h0000_1006, 0,
                  exp_pa(32'h0000_1006, s + 32'h5000), 1'b0);
        end
    endtask

    task automatic t_translate();
        logic [31:0] e;
        reg_write(3'd1, 32'h0001_0000);
        reg_write(3'd0, 32'h0000_0001);
        e = 32'h0123_4506;
        xlate("R6 R7 basic", 32'hFF00_3ABC, 1'b0, 1'b1, 32'h0010_000C, e, 2,
              exp_pa(e, 32'hFF00_3ABC), 1'b0);
        e = 32'hFF12_3486;
        xlate("R7 high bits dropped", 32'hFFFF_F001, 1'b1, 1'b1,
              32'h0010_0000 + 32'h3FFC, e, 0, exp_pa(e, 32'hFFFF_F001), 1'b0);
        reg_write(3'd0, 32'h0000_001D);
        e = 32'h0000_0102;
        xlate("R7 start boundary code 7", 32'h8000_0FFF, 1'b0, 1'b1, 32'h0010_0000, e, 1,
              exp_pa(e, 32'h8000_0FFF), 1'b0);
    endtask

    task automatic t_faults();
        reg_write(3'd0, 32'h0000_0009);
        xlate("R8 invalid entry", 32'hFC00_2100, 1'b0, 1'b1, 32'h0010_0008,
              32'h0777_7704, 0, 32'h0, 1'b1);
        xlate("R9 write to read-only", 32'hFC00_2100, 1'b1, 1'b1, 32'h0010_0008,
              32'h0777_7782, 0, 32'h0, 1'b1);
        xlate("R9 read of read-only", 32'hFC00_2100, 1'b0, 1'b1, 32'h0010_0008,
              32'h0777_7782, 0, exp_pa(32'h0777_7782, 32'hFC00_2100), 1'b0);
    endtask

    task automatic t_busy();
        logic [31:0] e;
        e = 32'h0004_2006;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'hFC00_7010;
        @(negedge clk);
        req_addr = 32'hFC00_9999;
        chk("R10 busy not ready", 32'(req_ready), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 fetch addr unchanged", mem_rd_addr, 32'h0010_001C);
        mem_rd_data_valid = 1'b1; mem_rd_data = bswap(e);
        @(negedge clk);
        mem_rd_data_valid = 1'b0;
        chk("R10 busy rsp_valid", 32'(rsp_valid), 32'd1);
        chk("R10 first request answered", rsp_addr, exp_pa(e, 32'hFC00_7010));
        @(negedge clk);
        chk("R10 no second fetch", 32'(mem_rd_valid), 32'd0);
        chk("R10 no second response", 32'(rsp_valid), 32'd0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_disabled();
        t_window_codes();
        t_translate();
        t_faults();
        t_busy();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual timeout expected completion");
            finish_run();
        end
    end
endmodule